// File: doc/BRIEF.md
# Serial Pin Chain Shift Engine

This block extends the pins of a host through a chain of external shift registers. The chain has up to 32 port positions, and each port carries 1 to 4 bits. The engine shifts the programmed output levels out on a data line. It samples returned input levels on a second data line in the same bit slots, and it closes every scan with a load strobe. The serial clock is derived from the system clock by a programmable divisor. A bitmap takes ports out of the chain, and disabled ports cost no bit slots.

Software configures the engine through a small register port. That port holds the port width, the divisor, the enable bitmap, one output source word per port and one captured input word per bit index. A scan is started once with a trigger bit, or repeated back to back with an auto-repeat bit. The captured input words change only at the load strobe, so every read returns the values of one whole scan.

A single state machine sequences the scan:
- `ST_IDLE` holds the serial clock high. It leaves on `start`, which is the trigger or auto-repeat. It goes to `ST_SHIFT` when some port is enabled and to `ST_LATCH` when none is.
- `ST_SHIFT` runs one bit slot per divisor period. At the end of a slot it moves to the next bit, or to the next enabled port (`advance`). After the last bit of the last enabled port it goes to `ST_LATCH` (`finish`).
- `ST_LATCH` lasts one cycle and always returns to `ST_IDLE` (`settle`).

Top module: `serial_pin_chain`

## Requirements
- R1: After reset, the registers read as follows: control 0, divisor 2, enable bitmap 0, every source word 0 and every input word 0. The pins sit at sio_clk=1, sio_dout=0 and sio_load=0.
- R2: The register map is as follows.
  - Address 0x00 is control: width-minus-one in [1:0], auto-repeat in [2], and a one-shot trigger in [3] that always reads 0.
  - Address 0x01 is the divisor in [11:0].
  - Address 0x02 is the 32-bit port enable bitmap.
  - Address 0x20+n is the source word of port n, in [11:0].
  - Address 0x40+b is the input word for bit index b.
  - All other bits and addresses read 0.
- R3: A scan visits enabled ports in ascending order, and within a port it visits bits 0 up to width-minus-one. Ports whose bitmap bit is 0 get no bit slot.
- R4: Bit k of port n is driven with bit 3k of that port's source word. Bits 3k+1 and 3k+2 have no effect on the driven level.
- R5: The serial clock period is D system cycles, low for floor(D/2) cycles and then high. A programmed divisor below 2 behaves as 2.
- R6: sio_dout changes only where sio_clk falls and holds through the high phase. Outside bit slots sio_dout is 0. sio_din is sampled during the high phase of each slot.
- R7: In the input word for bit index b, bit n holds the level sampled for port n, bit b. Positions not scanned in the last scan read 0.
- R8: sio_load is high for exactly one cycle, with sio_clk high, after the last bit slot. The input words change only at the end of that cycle.
- R9: Writing 1 to the trigger bit starts exactly one scan. With auto-repeat set, a new scan starts right after each load strobe. Clearing auto-repeat lets the current scan finish, and then the clock stays idle.
- R10: With an all-zero bitmap, a scan consists only of the load strobe, with no serial clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sio_clk | output | 1 | Serial chain clock |
| sio_dout | output | 1 | Serial output data |
| sio_din | input | 1 | Serial input data |
| sio_load | output | 1 | End-of-scan load strobe |

## Verification
Two things can fall in the same cycle: a register write that changes what the chain drives, and the scan itself. One case is a source word or control write landing mid-scan. The other is the load strobe that commits the input words while software reads them. The bench reads an input word while a scan is running and expects the previous scan's value; after the strobe it expects the new one. It also clears auto-repeat in the middle of a running scan and checks that exactly that scan's bits still arrive and that no further clock edge follows.

// File: rtl/spc_pkg.sv
`timescale 1ns/1ps
package spc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } scan_state_e;

    localparam logic [1:0] PAGE_CTRL = 2'd0;
    localparam logic [1:0] PAGE_SRC  = 2'd1;
    localparam logic [1:0] PAGE_IN   = 2'd2;

    localparam logic [4:0] OFS_CTRL = 5'd0;
    localparam logic [4:0] OFS_DIV  = 5'd1;
    localparam logic [4:0] OFS_MASK = 5'd2;
endpackage

// File: rtl/spc_divider.sv
`timescale 1ns/1ps
module spc_divider #(
    parameter int DIVW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            sclk,
    output logic            rise,
    output logic            last
);
    logic [DIVW-1:0] cnt_q;
    logic [DIVW-1:0] eff;
    logic [DIVW-1:0] half;

    // divisors below two are raised to two
    assign eff  = (div < DIVW'(2)) ? DIVW'(2) : div;
    assign half = eff >> 1;

    assign sclk = !run || (cnt_q >= half);
    assign rise = run && (cnt_q == half);
    assign last = run && (cnt_q == eff - DIVW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIVW'(1);
    end
endmodule

// File: rtl/spc_picker.sv
`timescale 1ns/1ps
module spc_picker #(
    parameter int NPORTS = 32,
    parameter int PW     = 5
) (
    input  logic [NPORTS-1:0] mask,
    input  logic [PW-1:0]     cur,
    input  logic              from_start,
    output logic [PW-1:0]     nxt,
    output logic              found
);
    // lowest enabled port above cur (or lowest overall when from_start)
    always_comb begin
        nxt   = '0;
        found = 1'b0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            if (mask[i] && (from_start || (i > int'(cur)))) begin
                nxt   = PW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/spc_capture.sv
`timescale 1ns/1ps
module spc_capture #(
    parameter int NPORTS  = 32,
    parameter int MAXBITS = 4,
    parameter int PW      = 5,
    parameter int BW      = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear,
    input  logic                             sample,
    input  logic [BW-1:0]                    bidx,
    input  logic [PW-1:0]                    pidx,
    input  logic                             din,
    input  logic                             commit,
    output logic [MAXBITS-1:0][NPORTS-1:0]   words
);
    logic [MAXBITS-1:0][NPORTS-1:0] shadow_q;

    for (genvar gb = 0; gb < MAXBITS; gb++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow_q[gb] <= '0;
            else if (clear)
                shadow_q[gb] <= '0;
            else if (sample && (bidx == BW'(gb)))
                shadow_q[gb][pidx] <= din;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[gb] <= '0;
            else if (commit)
                words[gb] <= shadow_q[gb];
        end
    end
endmodule

// File: rtl/serial_pin_chain.sv
`timescale 1ns/1ps
module serial_pin_chain
    import spc_pkg::*;
#(
    parameter int NPORTS  = 32,
    parameter int MAXBITS = 4,
    parameter int DIVW    = 12,
    parameter int AW      = 7,
    parameter int DW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          sio_clk,
    output logic          sio_dout,
    input  logic          sio_din,
    output logic          sio_load
);
    localparam int PW       = $clog2(NPORTS);
    localparam int BW       = $clog2(MAXBITS);
    localparam int SRCW     = 3 * MAXBITS;
    localparam int AUTO_BIT = BW;
    localparam int GO_BIT   = BW + 1;

    // configuration
    logic [BW-1:0]             width_q;
    logic                      auto_q;
    logic                      go_q;
    logic [DIVW-1:0]           div_q;
    logic [NPORTS-1:0]         mask_q;
    logic [MAXBITS-1:0][2:0]   src_q [NPORTS];

    // sequencing
    scan_state_e               state_q, state_d;
    logic [PW-1:0]             port_q;
    logic [BW-1:0]             bit_q;

    logic                      sclk_lvl, slot_rise, slot_last;
    logic [PW-1:0]             nxt_port;
    logic                      nxt_found;
    logic                      start;
    logic                      port_done;
    logic [MAXBITS-1:0][NPORTS-1:0] in_words;

    logic [1:0]                page;
    logic [4:0]                ofs;
    logic                      wr_ctrl;

    assign page    = reg_addr[6:5];
    assign ofs     = reg_addr[4:0];
    assign wr_ctrl = reg_we && (page == PAGE_CTRL) && (ofs == OFS_CTRL);

    assign start     = (state_q == ST_IDLE) && (auto_q || go_q);
    assign port_done = (bit_q == width_q);

    spc_divider #(.DIVW(DIVW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SHIFT),
        .div   (div_q),
        .sclk  (sclk_lvl),
        .rise  (slot_rise),
        .last  (slot_last)
    );

    spc_picker #(.NPORTS(NPORTS), .PW(PW)) u_pick (
        .mask       (mask_q),
        .cur        (port_q),
        .from_start (state_q == ST_IDLE),
        .nxt        (nxt_port),
        .found      (nxt_found)
    );

    spc_capture #(.NPORTS(NPORTS), .MAXBITS(MAXBITS), .PW(PW), .BW(BW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .sample (state_q == ST_SHIFT && slot_rise),
        .bidx   (bit_q),
        .pidx   (port_q),
        .din    (sio_din),
        .commit (state_q == ST_LATCH),
        .words  (in_words)
    );

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
            auto_q  <= 1'b0;
            go_q    <= 1'b0;
            div_q   <= DIVW'(2);
            mask_q  <= '0;
            for (int i = 0; i < NPORTS; i++)
                src_q[i] <= '0;
        end else begin
            if (wr_ctrl && reg_wdata[GO_BIT])
                go_q <= 1'b1;
            else if (start)
                go_q <= 1'b0;
            if (wr_ctrl) begin
                width_q <= reg_wdata[BW-1:0];
                auto_q  <= reg_wdata[AUTO_BIT];
            end
            if (reg_we && page == PAGE_CTRL && ofs == OFS_DIV)
                div_q <= reg_wdata[DIVW-1:0];
            if (reg_we && page == PAGE_CTRL && ofs == OFS_MASK)
                mask_q <= reg_wdata[NPORTS-1:0];
            if (reg_we && page == PAGE_SRC && int'(ofs) < NPORTS)
                src_q[ofs[PW-1:0]] <= reg_wdata[SRCW-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = nxt_found ? ST_SHIFT : ST_LATCH;
            ST_SHIFT: if (slot_last && port_done && !nxt_found) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
            bit_q  <= '0;
        end else if (start) begin
            port_q <= nxt_port;
            bit_q  <= '0;
        end else if (state_q == ST_SHIFT && slot_last) begin
            if (port_done) begin
                bit_q <= '0;
                if (nxt_found)
                    port_q <= nxt_port;
            end else begin
                bit_q <= bit_q + BW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        sio_clk  = 1'b1;
        sio_dout = 1'b0;
        sio_load = 1'b0;
        unique case (state_q)
            ST_SHIFT: begin
                sio_clk  = sclk_lvl;
                sio_dout = src_q[port_q][bit_q][0];
            end
            ST_LATCH: sio_load = 1'b1;
            default: ;
        endcase
    end

    // register reads
    always_comb begin
        reg_rdata = '0;
        unique case (page)
            PAGE_CTRL: begin
                if (ofs == OFS_CTRL) begin
                    reg_rdata[BW-1:0]     = width_q;
                    reg_rdata[AUTO_BIT]   = auto_q;
                end else if (ofs == OFS_DIV) begin
                    reg_rdata[DIVW-1:0]   = div_q;
                end else if (ofs == OFS_MASK) begin
                    reg_rdata[NPORTS-1:0] = mask_q;
                end
            end
            PAGE_SRC: if (int'(ofs) < NPORTS) reg_rdata[SRCW-1:0] = src_q[ofs[PW-1:0]];
            PAGE_IN:  if (int'(ofs) < MAXBITS) reg_rdata[NPORTS-1:0] = in_words[ofs[BW-1:0]];
            default: ;
        endcase
    end
endmodule

// File: rtl/spc_checker.sv
`timescale 1ns/1ps
module spc_checker #(
    parameter int NPORTS  = 32,
    parameter int MAXBITS = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           reg_we,
    input logic                           sio_clk,
    input logic                           sio_dout,
    input logic                           sio_load,
    input logic [MAXBITS-1:0][NPORTS-1:0] in_words
);
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sio_load |=> !sio_load) else $error("load strobe longer than one cycle"); // R8

    AST_LOAD_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sio_load |-> (sio_clk && !sio_dout)) else $error("load strobe with clock low or data set"); // R6

    AST_DOUT_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_clk && $past(sio_clk) && !$past(reg_we) && !sio_load) |-> $stable(sio_dout))
        else $error("data out moved during high phase"); // R6

    AST_INPUT_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_words) |-> $past(sio_load)) else $error("input words changed outside load"); // R8
endmodule

bind serial_pin_chain spc_checker #(.NPORTS(NPORTS), .MAXBITS(MAXBITS)) u_spc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .sio_clk  (sio_clk),
    .sio_dout (sio_dout),
    .sio_load (sio_load),
    .in_words (in_words)
);

// File: tb/test_serial_pin_chain.sv
`timescale 1ns/1ps
module test_serial_pin_chain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sio_clk, sio_dout, sio_load;
    logic        sio_din = 1'b0;

    int n_checks = 0;
    int n_errs   = 0;
    int falls    = 0;
    bit mon_on   = 1'b0;
    bit exp_q[$];
    bit din_q[$];
    logic [11:0] cfgm [32];
    logic [31:0] exp_in [4];

    always #2 clk = ~clk;   // 250 MHz

    serial_pin_chain i_serial_pin_chain (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sio_clk(sio_clk),
        .sio_dout(sio_dout), .sio_din(sio_din), .sio_load(sio_load)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare one expected bit per serial rising edge (R3 R4)
    always @(posedge sio_clk) begin
        if (mon_on) begin
            #1;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errs++;
                $display("FAIL R3 unexpected bit slot actual=%b expected=none", sio_dout);
            end else begin
                automatic bit e = exp_q.pop_front();
                if (sio_dout !== e) begin
                    n_errs++;
                    $display("FAIL R3 R4 serial bit actual=%b expected=%b", sio_dout, e);
                end
            end
        end
    end

    // chain model: present next input bit at each falling edge
    always @(negedge sio_clk) begin
        if (mon_on) begin
            falls++;
            sio_din = (din_q.size() > 0) ? din_q.pop_front() : 1'b0;
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // driver: push expected bits and inputs of one scan in chain order
    task automatic plan_scan(input int width_m1, input logic [31:0] mask);
        for (int b = 0; b < 4; b++) exp_in[b] = '0;
        for (int p = 0; p < 32; p++) begin
            if (mask[p]) begin
                for (int k = 0; k <= width_m1; k++) begin
                    automatic bit d = bit'($urandom % 2);
                    exp_q.push_back(cfgm[p][3*k]);
                    din_q.push_back(d);
                    exp_in[k][p] = d;
                end
            end
        end
    endtask

    task automatic wait_load();
        @(posedge sio_load);
        @(negedge clk);
        chk("R8 load high with clock high", {30'd0, sio_load, sio_clk}, 32'h3);
        @(negedge clk);
        chk("R8 load single cycle", {31'd0, sio_load}, 32'h0);
    endtask

    task automatic measure(input int low_exp, input int per_exp, input string tag);
        time t0, t1, t2;
        @(negedge sio_clk); t0 = $time;
        @(posedge sio_clk); t1 = $time;
        @(negedge sio_clk); t2 = $time;
        chk({tag, " low phase"}, 32'((t1 - t0) / 4), 32'(low_exp));
        chk({tag, " period"},    32'((t2 - t0) / 4), 32'(per_exp));
    endtask

    task automatic check_words(input string tag);
        logic [31:0] v;
        for (int b = 0; b < 4; b++) begin
            rd(7'h40 + 7'(b), v);
            chk(tag, v, exp_in[b]);
        end
    endtask

    initial begin
        logic [31:0] v;
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        mon_on = 1'b1;

        // R1 reset state
        rd(7'h00, v); chk("R1 control", v, 32'h0);
        rd(7'h01, v); chk("R1 divisor", v, 32'h2);
        rd(7'h02, v); chk("R1 bitmap", v, 32'h0);
        rd(7'h25, v); chk("R1 source word", v, 32'h0);
        rd(7'h40, v); chk("R1 input word", v, 32'h0);
        chk("R1 pins", {29'd0, sio_clk, sio_dout, sio_load}, 32'h4);

        // R2 register map
        wr(7'h00, 32'h0000_0003); rd(7'h00, v); chk("R2 control", v, 32'h3);
        wr(7'h3F, 32'hFFFF_FFFF); rd(7'h3F, v); chk("R2 source width", v, 32'h0000_0FFF);
        wr(7'h02, 32'hA5A5_0001); rd(7'h02, v); chk("R2 bitmap", v, 32'hA5A5_0001);
        rd(7'h44, v); chk("R2 unmapped", v, 32'h0);

        for (int p = 0; p < 32; p++) begin
            cfgm[p] = 12'($urandom);
            if (p == 0) cfgm[p] = 12'h001;
            if (p == 3) cfgm[p] = 12'h006;   // R4 upper group bits only
            wr(7'h20 + 7'(p), {20'd0, cfgm[p]});
        end

        // scan A: three bits per port, ports 0,3,31, divisor 4
        wr(7'h01, 32'd4);
        wr(7'h02, 32'h8000_0009);
        plan_scan(2, 32'h8000_0009);
        wr(7'h00, 32'h0000_000A);
        rd(7'h00, v); chk("R2 trigger reads zero", v, 32'h2);
        measure(2, 4, "R5 divisor 4");
        rd(7'h40, v); chk("R8 word unchanged mid scan", v, 32'h0);
        wait_load();
        chk("R3 all bits shifted", 32'(exp_q.size()), 32'd0);
        check_words("R7 input words scan A");

        // scan B: four bits, ports 4..7, odd divisor, auto-repeat x3
        wr(7'h01, 32'd5);
        wr(7'h02, 32'h0000_00F0);
        plan_scan(3, 32'h0000_00F0);
        plan_scan(3, 32'h0000_00F0);
        plan_scan(3, 32'h0000_00F0);
        wr(7'h00, 32'h0000_0007);
        measure(2, 5, "R5 divisor 5");
        wait_load();
        wait_load();
        wr(7'h00, 32'h0000_0003);
        wait_load();
        chk("R9 three scans done", 32'(exp_q.size()), 32'd0);
        check_words("R7 input words scan B");
        f0 = falls;
        repeat (50) @(negedge clk);
        chk("R9 no restart after auto cleared", 32'(falls), 32'(f0));

        // scan C: divisor 1 clamps to 2, one bit on all ports
        wr(7'h01, 32'd1);
        wr(7'h02, 32'hFFFF_FFFF);
        plan_scan(0, 32'hFFFF_FFFF);
        wr(7'h00, 32'h0000_0008);
        measure(1, 2, "R5 divisor clamp");
        wait_load();
        chk("R3 scan C bits", 32'(exp_q.size()), 32'd0);
        check_words("R7 input words scan C");

        // scan D: empty bitmap
        wr(7'h02, 32'h0);
        for (int b = 0; b < 4; b++) exp_in[b] = '0;
        f0 = falls;
        wr(7'h00, 32'h0000_0008);
        wait_load();
        chk("R10 no clock edges", 32'(falls), 32'(f0));
        check_words("R10 input words cleared");

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule